// File: doc/BRIEF.md
# Cold Reset Boot Configuration Sequencer

This block orders a chip's exit from cold reset and captures the boot settings. An active-low power-on reset is brought into the crystal clock domain. After a programmable delay the block releases an early system reset. It then waits for the clock controller's ready handshake, asks the fuse reader for a read, and waits for the read to finish. Only after that does it capture the general-purpose boot bits.

The two boot mode bits are sampled directly by the rising edge of the power-on reset. The general-purpose boot bits are taken later, either from fuse values or from GPIO pins, as chosen by a select fuse. Once captured, the mode and the boot bits stay fixed until the next cold reset. A one-cycle strobe and a sticky valid flag announce that they are ready.

Top module: `cold_boot_seq`

## Requirements
- R1: While `por_n` is low, `early_rst_n`, `fuse_rd_req`, `boot_valid`, `boot_strobe`, `boot_mode` and `boot_cfg` are all 0.
- R2: `boot_mode` holds the value that `mode_pins` had at the rising edge of `por_n`. Changes to `mode_pins` before or after that edge have no effect.
- R3: `early_rst_n` rises at the (REL_DLY+3)-th rising edge of `xtal_clk` after `por_n` rises: two edges for synchronization, one to enter the delay state, and REL_DLY for the delay. REL_DLY is at least 2. Once high, it stays high until the next reset.
- R4: `fuse_rd_req` stays 0 until `clk_ready` is sampled high with the early reset released. It rises on that edge and stays high until `fuse_done` is sampled high.
- R5: No capture happens before the read completes. `boot_valid` and `boot_strobe` stay 0, however long `fuse_done` stays low.
- R6: `boot_cfg` takes `fuse_cfg` when `fuse_sel` is 1 and `gpio_cfg` when it is 0. All three are sampled on the edge that follows the edge at which `fuse_done` was seen high.
- R7: `boot_strobe` is high for exactly one cycle. `boot_valid` rises together with it and stays high.
- R8: After `boot_valid` is high, later changes to any configuration input leave `boot_mode` and `boot_cfg` unchanged.
- R9: Asserting `por_n` low in any state clears all outputs at once, without waiting for a clock. The next release runs the full sequence again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| xtal_clk | input | 1 | Crystal-domain clock |
| por_n | input | 1 | Active-low power-on reset |
| clk_ready | input | 1 | Clock controller reports root clocks usable |
| fuse_done | input | 1 | Fuse reader read-complete flag |
| mode_pins | input | MODE_W | Boot mode pins |
| gpio_cfg | input | GP_W | GPIO boot configuration bits |
| fuse_cfg | input | GP_W | Fuse boot configuration bits |
| fuse_sel | input | 1 | Select fuse: 1 = fuse bits, 0 = GPIO bits |
| early_rst_n | output | 1 | Early system reset, active low |
| fuse_rd_req | output | 1 | Request to the fuse reader |
| boot_mode | output | MODE_W | Latched boot mode |
| boot_cfg | output | GP_W | Latched general-purpose boot bits |
| boot_valid | output | 1 | Latched values are stable |
| boot_strobe | output | 1 | One-cycle pulse on capture |

## Verification
The hardest case to reach from the ports is a reset that returns in the middle of the sequence. That includes the delay window, where no output changes yet. The bench releases `por_n` and pulls it low again after each count of edges from 1 to 9, so every state is hit. It checks that the outputs clear at once and that a full boot afterwards works. Mode and configuration pins carry decoy values during reset and during the waits, and different ones after capture. Together with sweeps over the select fuse and every 4-bit pattern, this shows that only the values at the defined sample points reach the outputs.

// File: rtl/cold_boot_pkg.sv
// Shared types for the cold reset boot sequencer.
package cold_boot_pkg;
    typedef enum logic [2:0] {
        ST_RESET      = 3'd0,
        ST_EARLY_WAIT = 3'd1,
        ST_CLK_WAIT   = 3'd2,
        ST_FUSE_READ  = 3'd3,
        ST_LATCH      = 3'd4,
        ST_RUN        = 3'd5
    } seq_state_e;
endpackage

// File: rtl/cb_reset_sync.sv
// Reset synchronizer: asynchronous assertion, release after STAGES xtal edges.
// Assumes arst_n may change at any time relative to clk.
module cb_reset_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic arst_n,
    output logic rel_n
);
    logic [STAGES-1:0] chain;

    genvar i;
    generate
        for (i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                // First stage takes a constant one once reset lifts.
                always_ff @(posedge clk or negedge arst_n) begin
                    if (!arst_n) chain[0] <= 1'b0;
                    else         chain[0] <= 1'b1;
                end
            end else begin : g_next
                // Later stages shift the release along.
                always_ff @(posedge clk or negedge arst_n) begin
                    if (!arst_n) chain[i] <= 1'b0;
                    else         chain[i] <= chain[i-1];
                end
            end
        end
    endgenerate

    assign rel_n = chain[STAGES-1];
endmodule

// File: rtl/cb_release_timer.sv
// Release delay counter: done is high in the DLY-th cycle of a run.
// Assumes run stays high until done is seen; the count clears when run drops.
module cb_release_timer #(
    parameter int DLY = 3
) (
    input  logic clk,
    input  logic arst_n,
    input  logic run,
    output logic done
);
    localparam int CW = $clog2(DLY + 1);
    localparam logic [CW-1:0] LAST = CW'(DLY - 1);

    logic [CW-1:0] cnt;

    // Count cycles spent in the delay state.
    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n)  cnt <= '0;
        else if (run) cnt <= cnt + 1'b1;
        else          cnt <= '0;
    end

    assign done = run && (cnt == LAST);
endmodule

// File: rtl/cb_seq_fsm.sv
// Cold reset sequencer state machine.
// The order is: delay, early reset release, clock-ready wait, fuse read, capture, run.
// Assumes clk_ready and fuse_done are already synchronous to clk.
module cb_seq_fsm
    import cold_boot_pkg::*;
(
    input  logic       clk,
    input  logic       arst_n,
    input  logic       rel_n,
    input  logic       tmr_done,
    input  logic       clk_ready,
    input  logic       fuse_done,
    output seq_state_e state,
    output logic       tmr_run,
    output logic       early_rst_n,
    output logic       fuse_rd_req,
    output logic       cap_en
);
    seq_state_e nxt;

    // Next-state selection.
    always_comb begin
        nxt = state;
        unique case (state)
            ST_RESET:      if (rel_n)     nxt = ST_EARLY_WAIT;
            ST_EARLY_WAIT: if (tmr_done)  nxt = ST_CLK_WAIT;
            ST_CLK_WAIT:   if (clk_ready) nxt = ST_FUSE_READ;
            ST_FUSE_READ:  if (fuse_done) nxt = ST_LATCH;
            ST_LATCH:                     nxt = ST_RUN;
            ST_RUN:                       nxt = ST_RUN;
            default:                      nxt = ST_RESET;
        endcase
    end

    // State register; a power-on reset returns it to RESET at once.
    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) state <= ST_RESET;
        else         state <= nxt;
    end

    assign tmr_run     = (state == ST_EARLY_WAIT);
    assign early_rst_n = (state != ST_RESET) && (state != ST_EARLY_WAIT);
    assign fuse_rd_req = (state == ST_FUSE_READ);
    assign cap_en      = (state == ST_LATCH);
endmodule

// File: rtl/cb_boot_capture.sv
// Boot value capture. The mode bits are sampled by the por_n rising edge.
// The general-purpose bits come from fuse or GPIO, per the select fuse, when cap_en is high.
// Outputs clear asynchronously on power-on reset and then hold until the next one.
module cb_boot_capture #(
    parameter int MODE_W = 2,
    parameter int GP_W   = 4
) (
    input  logic              clk,
    input  logic              arst_n,
    input  logic [MODE_W-1:0] mode_pins,
    input  logic              cap_en,
    input  logic [GP_W-1:0]   gpio_cfg,
    input  logic [GP_W-1:0]   fuse_cfg,
    input  logic              fuse_sel,
    output logic [MODE_W-1:0] boot_mode,
    output logic [GP_W-1:0]   boot_cfg,
    output logic              boot_valid,
    output logic              boot_strobe
);
    logic [MODE_W-1:0] mode_smp;
    logic [GP_W-1:0]   cfg_src;

    // Sample the mode pins on the reset release edge itself.
    always_ff @(posedge arst_n) begin
        mode_smp <= mode_pins;
    end

    genvar b;
    generate
        for (b = 0; b < GP_W; b++) begin : g_sel
            assign cfg_src[b] = fuse_sel ? fuse_cfg[b] : gpio_cfg[b];
        end
    endgenerate

    // Capture the boot values once; hold them until the next reset.
    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) begin
            boot_mode <= '0;
            boot_cfg  <= '0;
        end else if (cap_en && !boot_valid) begin
            boot_mode <= mode_smp;
            boot_cfg  <= cfg_src;
        end
    end

    // Sticky valid flag and one-cycle strobe.
    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) begin
            boot_valid  <= 1'b0;
            boot_strobe <= 1'b0;
        end else begin
            boot_valid  <= boot_valid | cap_en;
            boot_strobe <= cap_en && !boot_valid;
        end
    end
endmodule

// File: rtl/cold_boot_seq.sv
// Top of the cold reset boot sequencer.
// Assumes clk_ready and fuse_done are synchronous to xtal_clk. REL_DLY below 2 is raised to 2.
module cold_boot_seq #(
    parameter int MODE_W   = 2,
    parameter int GP_W     = 4,
    parameter int REL_DLY  = 3,
    parameter int SYNC_STG = 2
) (
    input  logic              xtal_clk,
    input  logic              por_n,
    input  logic              clk_ready,
    input  logic              fuse_done,
    input  logic [MODE_W-1:0] mode_pins,
    input  logic [GP_W-1:0]   gpio_cfg,
    input  logic [GP_W-1:0]   fuse_cfg,
    input  logic              fuse_sel,
    output logic              early_rst_n,
    output logic              fuse_rd_req,
    output logic [MODE_W-1:0] boot_mode,
    output logic [GP_W-1:0]   boot_cfg,
    output logic              boot_valid,
    output logic              boot_strobe
);
    import cold_boot_pkg::*;

    localparam int EFF_DLY = (REL_DLY < 2) ? 2 : REL_DLY;

    logic       rel_n;
    logic       tmr_run;
    logic       tmr_done;
    logic       cap_en;
    seq_state_e state;

    cb_reset_sync #(.STAGES(SYNC_STG)) u_sync (
        .clk    (xtal_clk),
        .arst_n (por_n),
        .rel_n  (rel_n)
    );

    cb_release_timer #(.DLY(EFF_DLY)) u_tmr (
        .clk    (xtal_clk),
        .arst_n (por_n),
        .run    (tmr_run),
        .done   (tmr_done)
    );

    cb_seq_fsm u_fsm (
        .clk         (xtal_clk),
        .arst_n      (por_n),
        .rel_n       (rel_n),
        .tmr_done    (tmr_done),
        .clk_ready   (clk_ready),
        .fuse_done   (fuse_done),
        .state       (state),
        .tmr_run     (tmr_run),
        .early_rst_n (early_rst_n),
        .fuse_rd_req (fuse_rd_req),
        .cap_en      (cap_en)
    );

    cb_boot_capture #(.MODE_W(MODE_W), .GP_W(GP_W)) u_cap (
        .clk         (xtal_clk),
        .arst_n      (por_n),
        .mode_pins   (mode_pins),
        .cap_en      (cap_en),
        .gpio_cfg    (gpio_cfg),
        .fuse_cfg    (fuse_cfg),
        .fuse_sel    (fuse_sel),
        .boot_mode   (boot_mode),
        .boot_cfg    (boot_cfg),
        .boot_valid  (boot_valid),
        .boot_strobe (boot_strobe)
    );
endmodule

// File: rtl/cold_boot_seq_chk.sv
// Property checker for cold_boot_seq, attached by bind below.
module cold_boot_seq_chk #(
    parameter int MODE_W = 2,
    parameter int GP_W   = 4
) (
    input logic              xtal_clk,
    input logic              por_n,
    input logic              fuse_done,
    input logic              early_rst_n,
    input logic              fuse_rd_req,
    input logic [MODE_W-1:0] boot_mode,
    input logic [GP_W-1:0]   boot_cfg,
    input logic              boot_valid,
    input logic              boot_strobe
);
    AST_REQ_AFTER_RELEASE: assert property (@(posedge xtal_clk) disable iff (!por_n)
        fuse_rd_req |-> early_rst_n);                                          // R4
    AST_NO_EARLY_CAPTURE: assert property (@(posedge xtal_clk) disable iff (!por_n)
        boot_strobe |-> ($past(fuse_done, 2) && $past(fuse_rd_req, 2)));       // R5
    AST_STROBE_SINGLE: assert property (@(posedge xtal_clk) disable iff (!por_n)
        boot_strobe |=> !boot_strobe);                                         // R7
    AST_VALID_ON_STROBE: assert property (@(posedge xtal_clk) disable iff (!por_n)
        $rose(boot_valid) |-> boot_strobe);                                    // R7
    AST_VALUES_FROZEN: assert property (@(posedge xtal_clk) disable iff (!por_n)
        boot_valid |=> (boot_valid && $stable(boot_cfg) && $stable(boot_mode))); // R8
    AST_EARLY_STAYS: assert property (@(posedge xtal_clk) disable iff (!por_n)
        early_rst_n |=> early_rst_n);                                          // R3
endmodule

bind cold_boot_seq cold_boot_seq_chk #(.MODE_W(MODE_W), .GP_W(GP_W)) u_chk (
    .xtal_clk    (xtal_clk),
    .por_n       (por_n),
    .fuse_done   (fuse_done),
    .early_rst_n (early_rst_n),
    .fuse_rd_req (fuse_rd_req),
    .boot_mode   (boot_mode),
    .boot_cfg    (boot_cfg),
    .boot_valid  (boot_valid),
    .boot_strobe (boot_strobe)
);

// File: tb/sim_cold_boot_seq.sv
module sim_cold_boot_seq;
    localparam int CLK_P = 10;
    localparam int MW    = 2;
    localparam int GW    = 4;
    localparam int DLY   = 3;

    logic          xtal_clk = 1'b0;
    logic          por_n = 1'b0;
    logic          clk_ready = 1'b0;
    logic          fuse_done = 1'b0;
    logic [MW-1:0] mode_pins = '0;
    logic [GW-1:0] gpio_cfg = '0;
    logic [GW-1:0] fuse_cfg = '0;
    logic          fuse_sel = 1'b0;
    logic          early_rst_n, fuse_rd_req, boot_valid, boot_strobe;
    logic [MW-1:0] boot_mode;
    logic [GW-1:0] boot_cfg;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    always #(CLK_P/2) xtal_clk = ~xtal_clk;

    cold_boot_seq #(.MODE_W(MW), .GP_W(GW), .REL_DLY(DLY)) u0 (
        .xtal_clk(xtal_clk), .por_n(por_n), .clk_ready(clk_ready), .fuse_done(fuse_done),
        .mode_pins(mode_pins), .gpio_cfg(gpio_cfg), .fuse_cfg(fuse_cfg), .fuse_sel(fuse_sel),
        .early_rst_n(early_rst_n), .fuse_rd_req(fuse_rd_req), .boot_mode(boot_mode),
        .boot_cfg(boot_cfg), .boot_valid(boot_valid), .boot_strobe(boot_strobe)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    // R1: every output reads zero
    task automatic chk_clear(input string req);
        chk(req, {early_rst_n, fuse_rd_req, boot_valid, boot_strobe, boot_mode, boot_cfg}, 0);
    endtask

    // One complete cold boot with decoys on the pins at every point that must be ignored.
    task automatic run_boot(input logic [MW-1:0] m, input logic [GW-1:0] g,
                            input logic [GW-1:0] f, input logic s,
                            input int rdy_dly, input int done_dly);
        int n;
        @(negedge xtal_clk);
        por_n = 1'b0; clk_ready = 1'b0; fuse_done = 1'b0;
        #1 chk_clear("R1/R9 async clear");
        mode_pins = ~m; gpio_cfg = ~g; fuse_cfg = ~f; fuse_sel = ~s;
        repeat (2) @(negedge xtal_clk);
        chk_clear("R1 held in reset");
        mode_pins = m;
        @(negedge xtal_clk);
        por_n = 1'b1;
        #1 mode_pins = ~m;                      // R2 decoy after the edge
        n = 0;
        do begin
            @(posedge xtal_clk); #1 n++;
            gpio_cfg = gpio_cfg + 1'b1;
        end while (!early_rst_n && n < 20);
        chk("R3 release edge count", n, DLY + 3);
        for (int k = 0; k < rdy_dly; k++) begin
            @(negedge xtal_clk);
            chk("R4 no request before ready", fuse_rd_req, 0);
            chk("R5 no capture before ready", boot_valid, 0);
        end
        @(negedge xtal_clk) clk_ready = 1'b1;
        @(posedge xtal_clk); #1 chk("R4 request after ready", fuse_rd_req, 1);
        for (int k = 0; k < done_dly; k++) begin
            @(negedge xtal_clk);
            fuse_sel = ~fuse_sel; gpio_cfg = ~gpio_cfg;
            chk("R4 request held", fuse_rd_req, 1);
            chk("R5 no capture before done", {boot_valid, boot_strobe}, 0);
        end
        @(negedge xtal_clk);
        fuse_done = 1'b1; gpio_cfg = g; fuse_cfg = f; fuse_sel = s;
        @(posedge xtal_clk); #1 chk("R4 request drops", fuse_rd_req, 0);
        chk("R5 not yet valid", boot_valid, 0);
        @(posedge xtal_clk); #1;
        chk("R7 strobe", boot_strobe, 1);
        chk("R7 valid", boot_valid, 1);
        chk("R6 source select", boot_cfg, s ? f : g);
        chk("R2 mode at edge", boot_mode, m);
        @(negedge xtal_clk);
        gpio_cfg = ~g; fuse_cfg = ~f; fuse_sel = ~s; mode_pins = ~m; fuse_done = 1'b0;
        repeat (2) @(posedge xtal_clk);
        #1;
        chk("R7 strobe single", boot_strobe, 0);
        chk("R7 valid sticky", boot_valid, 1);
        chk("R8 cfg frozen", boot_cfg, s ? f : g);
        chk("R8 mode frozen", boot_mode, m);
    endtask

    initial begin
        #(CLK_P * 100000);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge xtal_clk);
        chk_clear("R1 initial reset");
        // R6 sweep: both select values, all GPIO patterns, varied waits.
        for (int sel = 0; sel < 2; sel++) begin
            for (int g = 0; g < 16; g++) begin
                run_boot(MW'(g), GW'(g), GW'(g ^ 4'ha), sel[0], g % 4, (g / 4) % 3);
            end
        end
        // R9: pull reset low again after every count of edges into the sequence.
        for (int k = 1; k < 10; k++) begin
            @(negedge xtal_clk);
            por_n = 1'b0; clk_ready = 1'b1; fuse_done = 1'b1;
            @(negedge xtal_clk) por_n = 1'b1;
            repeat (k) @(posedge xtal_clk);
            #2 por_n = 1'b0;
            #1 chk_clear("R9 abort clears");
            repeat (2) @(negedge xtal_clk);
            chk_clear("R9 stays clear");
            run_boot(2'(k), GW'(k), GW'(~k), k[0], 1, 1);
        end
        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule